// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Command Logic

This block turns per-phase high-side and low-side switching commands into gate enable signals for a three-phase motor bridge. Each phase runs through its own chain. The low-side command can be inverted. Both commands pass a pulse-width filter that discards short glitches. A cross-conduction guard turns the whole phase off whenever both filtered commands are high. A dead-time gate then holds any turn-on until a programmed number of clock cycles has passed since the opposite side went off.

All phases share the clock, the synchronous reset, the inversion mode and the dead-time count. A fault supervisor can force the high side of a single phase off, or force every output off. Both disables act at the next clock edge and do not wait for the dead-time counter. Outputs are registered. A command that is held long enough reaches the gate `MIN_PULSE + 1` cycles after it changes.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and right after it, every gate output is low. A load of the dead-time counter happens in reset, so after reset is released no output rises until a full dead time has elapsed. The first possible rise is at the `dt`-th clock edge after the last reset edge.
- R2: When the opposite side is off and its dead time has elapsed, a gate output follows its filtered command. After the command changes and then stays stable, the output changes at the `MIN_PULSE + 1`-th rising clock edge.
- R3: A command level held for fewer than `MIN_PULSE` consecutive clock edges never changes any gate output.
- R4: While both filtered commands of a phase are high, both gate outputs of that phase are low from the next edge on. The two outputs of a phase are never high together.
- R5: After one side of a phase turns off, the other side can turn on no earlier than `dt` clock edges later, where `dt` is the value on `dt_cycles`. Any turn-on starts from a state where both outputs are low.
- R6: A value of 0 on `dt_cycles` selects the dead time `DT_DEFAULT` (50 cycles, 200 ns at 250 MHz).
- R7: With `lo_invert` = 0 (the default), the low-side output follows `cmd_lo`. With `lo_invert` = 1, it follows the complement of `cmd_lo`. In that mode an idle-high `cmd_lo` keeps the low side off.
- R8: `hs_disable[i]` high drives `gate_hi[i]` low at the next edge and leaves `gate_lo[i]` working. After it is released, the high side comes back only once the dead time counted from its forced turn-off has passed.
- R9: `all_disable` high drives every gate output low at the next edge. After it is released, the outputs come back only after the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | PHASES | High-side command per phase, bit i = phase i |
| cmd_lo | input | PHASES | Low-side command per phase, polarity set by lo_invert |
| lo_invert | input | 1 | 1 = low-side command is active low |
| dt_cycles | input | DT_W | Dead time in clock cycles, 0 selects DT_DEFAULT |
| hs_disable | input | PHASES | Per-phase forced off for the high side |
| all_disable | input | 1 | Forced off for every output |
| gate_hi | output | PHASES | High-side gate enable per phase |
| gate_lo | output | PHASES | Low-side gate enable per phase |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle between edges. They also assume that `dt_cycles` and `lo_invert` change only while the affected outputs are idle or while a dead-time window is deliberately being measured. The stimulus changes every input on the falling clock edge. It alters the dead time and the inversion mode only after all phases have returned to off. Glitch pulses are timed one cycle short of the filter threshold, and dead-time windows are sampled one cycle before and at the expected rise.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/hb_pulse_filter.sv
module hb_pulse_filter #(
  parameter int MIN_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt    <= 1'b0;
      run_cnt <= '0;
    end else if (raw == filt) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      filt    <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R3
  follow_raw_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> filt == $past(raw));

  // R3
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (raw == filt) |=> $stable(filt));

endmodule

// File: rtl/hb_deadtime_gate.sv
module hb_deadtime_gate
  import hb_gate_pkg::*;
#(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            want_hi,
  input  logic            want_lo,
  input  logic            hs_off,
  input  logic            all_off,
  input  logic [DT_W-1:0] dt_load,
  output gate_pair_t      gate
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic [DT_W-1:0] wait_cnt;
  logic            gap_done;
  gate_pair_t      gate_n;

  assign gap_done = (wait_cnt <= ONE);

  always_comb begin
    gate_n.hi = want_hi & ~hs_off & ~all_off & (gate.hi | (gap_done & ~gate.lo));
    gate_n.lo = want_lo & ~all_off & (gate.lo | (gap_done & ~gate.hi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate     <= '0;
      wait_cnt <= dt_load;
    end else begin
      gate <= gate_n;
      if (gate.hi | gate.lo) begin
        wait_cnt <= dt_load;
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate.hi && gate.lo));

  // R5
  on_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate.hi) || $rose(gate.lo)) |-> $past(!gate.hi && !gate.lo));

  // R8
  hs_force_chk: assert property (@(posedge clk) disable iff (rst)
    hs_off |=> !gate.hi);

  // R9
  all_force_chk: assert property (@(posedge clk) disable iff (rst)
    all_off |=> (!gate.hi && !gate.lo));

endmodule

// File: rtl/hb_phase.sv
module hb_phase
  import hb_gate_pkg::*;
#(
  parameter int MIN_PULSE = 18,
  parameter int DT_W      = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_hi,
  input  logic            cmd_lo,
  input  logic            lo_invert,
  input  logic [DT_W-1:0] dt_load,
  input  logic            hs_off,
  input  logic            all_off,
  output gate_pair_t      gate
);
  logic lo_true;
  logic f_hi;
  logic f_lo;
  logic want_hi;
  logic want_lo;

  assign lo_true = cmd_lo ^ lo_invert;

  hb_pulse_filter #(.MIN_CYC(MIN_PULSE)) u_filt_hi (
    .clk(clk), .rst(rst), .raw(cmd_hi), .filt(f_hi)
  );

  hb_pulse_filter #(.MIN_CYC(MIN_PULSE)) u_filt_lo (
    .clk(clk), .rst(rst), .raw(lo_true), .filt(f_lo)
  );

  assign want_hi = f_hi & ~f_lo;
  assign want_lo = f_lo & ~f_hi;

  hb_deadtime_gate #(.DT_W(DT_W)) u_dt (
    .clk(clk), .rst(rst),
    .want_hi(want_hi), .want_lo(want_lo),
    .hs_off(hs_off), .all_off(all_off),
    .dt_load(dt_load), .gate(gate)
  );

  // R4
  both_cmd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (f_hi && f_lo) |=> (!gate.hi && !gate.lo));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int PHASES     = 3,
  parameter int DT_W       = 10,
  parameter int DT_DEFAULT = 50,
  parameter int MIN_PULSE  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] cmd_hi,
  input  logic [PHASES-1:0] cmd_lo,
  input  logic              lo_invert,
  input  logic [DT_W-1:0]   dt_cycles,
  input  logic [PHASES-1:0] hs_disable,
  input  logic              all_disable,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo
);
  localparam logic [DT_W-1:0] DT_DEF_V = DT_W'(DT_DEFAULT);

  logic [DT_W-1:0] dt_eff;

  assign dt_eff = (dt_cycles == '0) ? DT_DEF_V : dt_cycles;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    gate_pair_t pair;

    hb_phase #(.MIN_PULSE(MIN_PULSE), .DT_W(DT_W)) u_phase (
      .clk(clk), .rst(rst),
      .cmd_hi(cmd_hi[p]), .cmd_lo(cmd_lo[p]),
      .lo_invert(lo_invert), .dt_load(dt_eff),
      .hs_off(hs_disable[p]), .all_off(all_disable),
      .gate(pair)
    );

    assign gate_hi[p] = pair.hi;
    assign gate_lo[p] = pair.lo;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;
  localparam int F   = 18;
  localparam int DTD = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_hi = 3'b000;
  logic [2:0] cmd_lo = 3'b000;
  logic       lo_inv = 1'b0;
  logic [9:0] dt = 10'd0;
  logic [2:0] hs_dis = 3'b000;
  logic       all_dis = 1'b0;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  int    q_at[$];
  int    q_ph[$];
  int    q_sd[$];
  int    q_v[$];
  string q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_gate_ctrl #(.PHASES(3), .DT_W(10), .DT_DEFAULT(DTD), .MIN_PULSE(F)) u_dut (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .lo_invert(lo_inv), .dt_cycles(dt), .hs_disable(hs_dis),
    .all_disable(all_dis), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int at, int ph, int sd, int v, string tag);
    q_at.push_back(at); q_ph.push_back(ph); q_sd.push_back(sd);
    q_v.push_back(v);   q_tag.push_back(tag);
  endtask

  // scoreboard monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q_at.size() > 0 && q_at[0] <= cyc) begin
      logic act;
      act = (q_sd[0] != 0) ? gate_lo[q_ph[0]] : gate_hi[q_ph[0]];
      chk(q_tag[0], $sformatf("ph%0d %s at %0d", q_ph[0], (q_sd[0] != 0) ? "lo" : "hi", q_at[0]),
          act, logic'(q_v[0] != 0));
      void'(q_at.pop_front()); void'(q_ph.pop_front()); void'(q_sd.pop_front());
      void'(q_v.pop_front());  void'(q_tag.pop_front());
    end
  end

  task automatic drain();
    while (q_at.size() > 0) @(negedge clk);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    int e;
    cmd_hi = 3'b010;
    tick(3);
    for (int p = 0; p < 3; p++) begin
      chk("R1", $sformatf("reset hi%0d", p), gate_hi[p], 1'b0);
      chk("R1", $sformatf("reset lo%0d", p), gate_lo[p], 1'b0);
    end
    rst = 1'b0;
    c = cyc;
    // R1 and R6: no rise before the default dead time after reset
    expect_at(c + DTD - 1, 1, 0, 0, "R1");
    expect_at(c + DTD, 1, 0, 1, "R6");
    drain();

    // R2: release follows with filter latency
    tick(1); c = cyc; cmd_hi[1] = 1'b0; dt = 10'd10;
    expect_at(c + F, 1, 0, 1, "R2");
    expect_at(c + F + 1, 1, 0, 0, "R2");
    drain();

    // R3: pulse one cycle short of the threshold
    tick(1); c = cyc; cmd_hi[0] = 1'b1;
    expect_at(c + F + 1, 0, 0, 0, "R3");
    expect_at(c + F + 4, 0, 0, 0, "R3");
    tick(F - 1); cmd_hi[0] = 1'b0;
    drain();

    // R2: turn-on
    tick(1); c = cyc; cmd_hi[0] = 1'b1;
    expect_at(c + F, 0, 0, 0, "R2");
    expect_at(c + F + 1, 0, 0, 1, "R2");
    drain();

    // R5: hand over high to low with dt = 10
    tick(1); c = cyc; cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
    e = c + F + 1;
    expect_at(c + F, 0, 0, 1, "R5");
    expect_at(e, 0, 0, 0, "R5");
    expect_at(e + 9, 0, 1, 0, "R5");
    expect_at(e + 10, 0, 1, 1, "R5");
    drain();

    // R4: both commands high
    tick(1); c = cyc; cmd_hi[0] = 1'b1;
    expect_at(c + F, 0, 1, 1, "R4");
    expect_at(c + F + 1, 0, 1, 0, "R4");
    expect_at(c + F + 1, 0, 0, 0, "R4");
    expect_at(c + F + 30, 0, 0, 0, "R4");
    expect_at(c + F + 30, 0, 1, 0, "R4");
    drain();
    tick(1); c = cyc; cmd_lo[0] = 1'b0;
    expect_at(c + F + 1, 0, 0, 1, "R2");
    drain();
    tick(1); c = cyc; cmd_hi[0] = 1'b0;
    expect_at(c + F + 1, 0, 0, 0, "R2");
    drain();

    // R7: inverting mode, idle-high input keeps low side off
    tick(1); c = cyc; lo_inv = 1'b1; cmd_lo = 3'b111;
    for (int p = 0; p < 3; p++) expect_at(c + F + 2, p, 1, 0, "R7");
    for (int p = 0; p < 3; p++) expect_at(c + F + 10, p, 1, 0, "R7");
    drain();
    tick(1); c = cyc; cmd_lo[2] = 1'b0;
    expect_at(c + F, 2, 1, 0, "R7");
    expect_at(c + F + 1, 2, 1, 1, "R7");
    drain();

    // R6: dt_cycles = 0 selects the default dead time
    tick(1); c = cyc; dt = 10'd0; cmd_lo[2] = 1'b1; cmd_hi[2] = 1'b1;
    e = c + F + 1;
    expect_at(e, 2, 1, 0, "R6");
    expect_at(e + DTD - 1, 2, 0, 0, "R6");
    expect_at(e + DTD, 2, 0, 1, "R6");
    drain();

    // R8: high-side disable, low side of another phase unaffected
    tick(1); c = cyc; hs_dis = 3'b110; cmd_lo[1] = 1'b0;
    expect_at(c + 1, 2, 0, 0, "R8");
    expect_at(c + F + 1, 1, 1, 1, "R8");
    drain();
    hs_dis = 3'b000;
    expect_at(c + DTD, 2, 0, 0, "R8");
    expect_at(c + DTD + 1, 2, 0, 1, "R8");
    drain();

    // R9: global disable, then return after the dead time
    tick(1); c = cyc; all_dis = 1'b1;
    expect_at(c + 1, 1, 1, 0, "R9");
    expect_at(c + 1, 2, 0, 0, "R9");
    expect_at(c + 20, 1, 1, 0, "R9");
    drain();
    all_dis = 1'b0;
    expect_at(c + DTD, 1, 1, 0, "R9");
    expect_at(c + DTD + 1, 1, 1, 1, "R9");
    expect_at(c + DTD + 1, 2, 0, 1, "R9");
    drain();

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule